// File: doc/BRIEF.md
# Preemptive Round-Robin Bus Arbiter

This block decides who owns a shared byte-serial bus. Four ordinary requesters (processor and DMA ports) each raise a request for a read or write transaction of a given byte count. The arbiter grants them in rotating order and times each byte on the bus. A separate set of event lines carries converter triggers and interrupts. Any pending event wins at the next byte boundary. It is sent as a single short code byte, and the interrupted transaction then continues from the byte where it stopped, not from its start.

A requester holds its request until it sees its completion pulse. It must drop the request in the following cycle. While it holds the grant, it drives one byte per byte slot, and the arbiter reports which byte of the transaction is on the bus. The block knows nothing about the contents of a byte. It only decides who owns each slot.

Top module: `bus_evt_arbiter`

## Requirements
- R1: During and after reset no grant, no event and no completion is signalled, and the rotation pointer starts at requester 0.
- R2: A granted transaction whose length field holds L occupies L+1 byte slots of BYTE_CYC cycles each. During those slots gnt_o is one-hot on its source, and byte_pos_o runs 0, 1, ... L.
- R3: done_o of the owning source pulses for one cycle, in the last cycle of its last byte, and only while that source holds the grant. The requester drops its request in the next cycle, and it is not granted again off the request seen in that pulse cycle.
- R4: Among the pending requesters, the first one found from the pointer upward (cyclic, ascending index) is granted. The pointer moves to the source after the granted one only when that transaction completes.
- R5: A request that arrives while the bus is idle is granted in the very next cycle.
- R6: Ownership of the bus changes only at byte boundaries, never inside a byte slot.
- R7: At a byte boundary a pending event is sent before any ordinary byte, whether that byte would start a new transaction or continue the current one.
- R8: An event occupies one byte slot with evt_vld_o high and evt_code_o = bit 7 set, bits 6:4 zero and bits 3:0 holding the event index. gnt_o is never high at the same time.
- R9: Several pending events are sent back to back, lowest index first. Repeated requests for an index that is already pending produce a single byte.
- R10: After a preemption the cut transaction resumes at its next byte position and keeps the bus ahead of other pending requesters. Preemption does not move the pointer.
- R11: The length is captured at grant time. Later changes of len_i for the owning source have no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_REQ | Transaction request per requester, held until done |
| len_i | input | N_REQ*LEN_W | Per-requester byte count minus one |
| evt_req_i | input | N_EVT | Event request pulses, one line per event index |
| gnt_o | output | N_REQ | One-hot owner of the current ordinary byte slot |
| done_o | output | N_REQ | Completion pulse of the owning transaction |
| byte_pos_o | output | LEN_W | Index of the ordinary byte on the bus |
| evt_vld_o | output | 1 | An event code byte occupies the bus |
| evt_code_o | output | 8 | Event code byte, zero when no event is sent |

## Verification
A wrong rotation pointer shows at the ports at the next contention, as a grant to the wrong requester in the first cycle of the next transaction. A corrupted remaining-byte count or position shows within one byte slot, as a wrong byte_pos_o, or as a done pulse arriving early or late against the length. A lost or wrongly cleared event bit shows at the next byte boundary, as a missing code byte or one sent out of index order. A transaction that fails to resume shows in the first ordinary slot after the events, as a wrong owner or a restarted position.

// File: rtl/bus_evt_arbiter_pkg.sv
package bus_evt_arbiter_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_TXN  = 2'd1,
    SLOT_EVT  = 2'd2
  } slot_e;

  localparam logic [3:0] EVT_TAG = 4'h8;

  function automatic logic [7:0] evt_byte(input logic [3:0] idx);
    return {EVT_TAG, idx};
  endfunction

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int N     = 4,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  input  logic [IDX_W-1:0] ptr_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  // scan downward so the candidate nearest the pointer is written last
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[(int'(ptr_i) + k) % N]) begin
        idx_o = IDX_W'((int'(ptr_i) + k) % N);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) assert_pick_in_req_R4 : assert (req_i[idx_o]);
  end

endmodule

// File: rtl/arb_evt_pick.sv
module arb_evt_pick #(
  parameter int N     = 8,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);

  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (pend_i[k]) begin
        idx_o = IDX_W'(k);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) assert_lowest_evt_R9 : assert (pend_i[idx_o] && ((pend_i & ((N'(1) << idx_o) - N'(1))) == '0));
  end

endmodule

// File: rtl/arb_byte_timer.sv
module arb_byte_timer #(
  parameter int BYTE_CYC = 8,
  localparam int CYC_W   = $clog2(BYTE_CYC)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic end_o
);

  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BYTE_CYC - 1);

  logic [CYC_W-1:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cyc_q <= '0;
    else if (!busy_i || cyc_q == CYC_LAST) cyc_q <= '0;
    else                               cyc_q <= cyc_q + 1'b1;
  end

  assign end_o = busy_i && (cyc_q == CYC_LAST);

  assert_slot_start_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i) |=> (cyc_q == '0));

endmodule

// File: rtl/bus_evt_arbiter.sv
module bus_evt_arbiter
  import bus_evt_arbiter_pkg::*;
#(
  parameter int N_REQ    = 4,
  parameter int N_EVT    = 8,
  parameter int LEN_W    = 3,
  parameter int BYTE_CYC = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_REQ-1:0]       req_i,
  input  logic [N_REQ*LEN_W-1:0] len_i,
  input  logic [N_EVT-1:0]       evt_req_i,
  output logic [N_REQ-1:0]       gnt_o,
  output logic [N_REQ-1:0]       done_o,
  output logic [LEN_W-1:0]       byte_pos_o,
  output logic                   evt_vld_o,
  output logic [7:0]             evt_code_o
);

  localparam int PTR_W = $clog2(N_REQ);
  localparam int EVT_W = $clog2(N_EVT);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(N_REQ - 1);

  slot_e             slot_q, slot_d;
  logic [PTR_W-1:0]  rr_ptr_q, rr_ptr_d, ptr_after;
  logic [PTR_W-1:0]  txn_src_q, txn_src_d;
  logic              txn_act_q, txn_act_d;
  logic [LEN_W-1:0]  txn_left_q, txn_left_d;
  logic [LEN_W-1:0]  txn_pos_q, txn_pos_d;
  logic [N_EVT-1:0]  evt_pend_q, evt_pend_d, pend_all;
  logic [EVT_W-1:0]  evt_cur_q, evt_cur_d;

  logic              slot_end, decide, txn_fin;
  logic [N_REQ-1:0]  done_vec, req_eff;
  logic [PTR_W-1:0]  rr_idx;
  logic              rr_any;
  logic [EVT_W-1:0]  ev_idx;
  logic              ev_any;

  arb_byte_timer #(.BYTE_CYC(BYTE_CYC)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (slot_q != SLOT_IDLE),
    .end_o  (slot_end)
  );

  assign decide   = (slot_q == SLOT_IDLE) || slot_end;
  assign txn_fin  = slot_end && (slot_q == SLOT_TXN) && (txn_left_q == '0);
  assign done_vec = txn_fin ? (N_REQ'(1) << txn_src_q) : '0;
  // the finishing source still shows its request this cycle
  assign req_eff  = req_i & ~done_vec;
  assign ptr_after = !txn_fin ? rr_ptr_q :
                     (txn_src_q == PTR_LAST) ? '0 : txn_src_q + 1'b1;
  assign pend_all = evt_pend_q | evt_req_i;

  arb_rr_pick #(.N(N_REQ)) u_rr (
    .req_i (req_eff),
    .ptr_i (ptr_after),
    .idx_o (rr_idx),
    .any_o (rr_any)
  );

  arb_evt_pick #(.N(N_EVT)) u_evt (
    .pend_i (pend_all),
    .idx_o  (ev_idx),
    .any_o  (ev_any)
  );

  always_comb begin
    slot_d     = slot_q;
    rr_ptr_d   = ptr_after;
    txn_src_d  = txn_src_q;
    txn_act_d  = txn_act_q;
    txn_left_d = txn_left_q;
    txn_pos_d  = txn_pos_q;
    evt_pend_d = pend_all;
    evt_cur_d  = evt_cur_q;

    if (slot_end && slot_q == SLOT_TXN) begin
      if (txn_left_q == '0) begin
        txn_act_d = 1'b0;
      end else begin
        txn_left_d = txn_left_q - 1'b1;
        txn_pos_d  = txn_pos_q + 1'b1;
      end
    end

    if (decide) begin
      if (ev_any) begin
        slot_d             = SLOT_EVT;
        evt_cur_d          = ev_idx;
        evt_pend_d[ev_idx] = 1'b0;
      end else if (txn_act_d) begin
        slot_d = SLOT_TXN;
      end else if (rr_any) begin
        slot_d     = SLOT_TXN;
        txn_act_d  = 1'b1;
        txn_src_d  = rr_idx;
        txn_left_d = len_i[int'(rr_idx)*LEN_W +: LEN_W];
        txn_pos_d  = '0;
      end else begin
        slot_d = SLOT_IDLE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q     <= SLOT_IDLE;
      rr_ptr_q   <= '0;
      txn_src_q  <= '0;
      txn_act_q  <= 1'b0;
      txn_left_q <= '0;
      txn_pos_q  <= '0;
      evt_pend_q <= '0;
      evt_cur_q  <= '0;
    end else begin
      slot_q     <= slot_d;
      rr_ptr_q   <= rr_ptr_d;
      txn_src_q  <= txn_src_d;
      txn_act_q  <= txn_act_d;
      txn_left_q <= txn_left_d;
      txn_pos_q  <= txn_pos_d;
      evt_pend_q <= evt_pend_d;
      evt_cur_q  <= evt_cur_d;
    end
  end

  always_comb begin
    gnt_o = '0;
    gnt_o[txn_src_q] = (slot_q == SLOT_TXN);
  end

  assign done_o     = done_vec;
  assign byte_pos_o = txn_pos_q;
  assign evt_vld_o  = (slot_q == SLOT_EVT);
  assign evt_code_o = evt_vld_o ? evt_byte(4'(evt_cur_q)) : 8'h00;

  assert_gnt_onehot_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  assert_no_overlap_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|gnt_o) && evt_vld_o));

  assert_done_owner_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|done_o) |-> ($onehot(done_o) && ((done_o & gnt_o) == done_o)));

  assert_byte_atomic_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q != SLOT_IDLE && !slot_end) |=>
      ($stable(gnt_o) && $stable(evt_vld_o) && $stable(evt_code_o) && $stable(byte_pos_o)));

  assert_evt_first_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_end && (|evt_pend_q)) |=> evt_vld_o);

  assert_ptr_hold_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|done_o) |=> $stable(rr_ptr_q));

  assert_resume_R10 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_q == SLOT_EVT && slot_end && txn_act_q && !(|pend_all)) |=>
      (gnt_o[$past(txn_src_q)] && $stable(byte_pos_o)));

endmodule

// File: tb/bus_evt_arbiter_tb_top.sv
module bus_evt_arbiter_tb_top;

  localparam int NR = 4;
  localparam int NE = 8;
  localparam int LW = 3;
  localparam int BC = 4;

  logic clk_i  = 1'b0;
  logic rst_ni = 1'b0;
  logic [NR-1:0]    req = '0;
  logic [NR*LW-1:0] len = '0;
  logic [NE-1:0]    evt = '0;
  logic [NR-1:0]    gnt, done;
  logic [LW-1:0]    pos;
  logic             evld;
  logic [7:0]       ecode;

  always #5 clk_i = ~clk_i;

  bus_evt_arbiter #(.N_REQ(NR), .N_EVT(NE), .LEN_W(LW), .BYTE_CYC(BC)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .len_i      (len),
    .evt_req_i  (evt),
    .gnt_o      (gnt),
    .done_o     (done),
    .byte_pos_o (pos),
    .evt_vld_o  (evld),
    .evt_code_o (ecode)
  );

  int checks = 0;
  int fails  = 0;
  int own_log[$];
  int pos_log[$];
  int code_log[$];
  int exp_own[$];
  int exp_pos[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // owner code: requester index, 16+event index, or -1 when idle
  task automatic step();
    int o;
    @(posedge clk_i);
    @(negedge clk_i);
    o = -1;
    for (int i = 0; i < NR; i++) if (gnt[i]) o = i;
    if (evld) o = 16 + int'(ecode[3:0]);
    if ((gnt != '0) && evld) chk(1'b0, "R8", int'(gnt), 0);
    own_log.push_back(o);
    pos_log.push_back(int'(pos));
    code_log.push_back(int'(ecode));
    if (done != '0) begin
      chk(done == gnt, "R3", int'(done), int'(gnt));
      req = req & ~done;
    end
  endtask

  task automatic run(input int lim);
    int n;
    n = 0;
    do begin
      step();
      n++;
    end while ((req != '0 || gnt != '0 || evld) && n < lim);
    chk(n < lim, "R2", n, lim);
  endtask

  task automatic ex(input int o, input int p);
    exp_own.push_back(o);
    exp_pos.push_back(p);
  endtask

  task automatic clear_logs();
    own_log.delete();
    pos_log.delete();
    code_log.delete();
    exp_own.delete();
    exp_pos.delete();
  endtask

  task automatic compare(input string tag);
    int s_own[$];
    int s_pos[$];
    int s_code[$];
    int i;
    i = 0;
    while (i < own_log.size()) begin
      if (own_log[i] < 0) begin
        i++;
        continue;
      end
      for (int k = 1; k < BC; k++)
        if (i + k < own_log.size() && own_log[i+k] != own_log[i])
          chk(1'b0, "R6", own_log[i+k], own_log[i]);
      s_own.push_back(own_log[i]);
      s_pos.push_back(pos_log[i]);
      s_code.push_back(code_log[i]);
      i += BC;
    end
    chk(s_own.size() == exp_own.size(), tag, s_own.size(), exp_own.size());
    for (int k = 0; k < s_own.size() && k < exp_own.size(); k++) begin
      chk(s_own[k] == exp_own[k], tag, s_own[k], exp_own[k]);
      if (exp_pos[k] >= 0) chk(s_pos[k] == exp_pos[k], tag, s_pos[k], exp_pos[k]);
      if (exp_own[k] >= 16) chk(s_code[k] == 128 + exp_own[k] - 16, "R8", s_code[k], 128 + exp_own[k] - 16);
    end
    clear_logs();
  endtask

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    // R1: quiet during reset, idle after it
    repeat (3) @(negedge clk_i);
    chk(gnt == '0, "R1", int'(gnt), 0);
    chk(!evld, "R1", int'(evld), 0);
    chk(done == '0, "R1", int'(done), 0);
    rst_ni = 1'b1;
    step();
    chk(own_log[0] == -1, "R1", own_log[0], -1);
    clear_logs();

    // R1 pointer at 0, R2 lengths, R5 latency: all four at once, lengths 1..4 bytes
    len = {3'd3, 3'd2, 3'd1, 3'd0};
    req = 4'hF;
    run(200);
    chk(own_log[0] == 0, "R5", own_log[0], 0);
    ex(0, 0);
    for (int p = 0; p < 2; p++) ex(1, p);
    for (int p = 0; p < 3; p++) ex(2, p);
    for (int p = 0; p < 4; p++) ex(3, p);
    compare("R2");

    // R11: length captured at grant; pointer now 0 so requester 1 is alone
    len[1*LW +: LW] = 3'd1;
    req = 4'b0010;
    step();
    len[1*LW +: LW] = 3'd7;
    run(200);
    ex(1, 0);
    ex(1, 1);
    compare("R11");

    // R7, R9, R10: events cut in after byte 1 of requester 2, requester 3 waits
    len[2*LW +: LW] = 3'd3;
    len[3*LW +: LW] = 3'd0;
    req = 4'b1100;
    repeat (BC + 1) step();
    evt = 8'h24;
    step();
    evt = 8'h20;
    step();
    evt = '0;
    run(200);
    ex(2, 0);
    ex(2, 1);
    ex(16 + 2, -1);
    ex(16 + 5, -1);
    ex(2, 2);
    ex(2, 3);
    ex(3, 0);
    compare("R10");

    // R7, R8, R9: events and a request arriving together on an idle bus
    len = '0;
    req = 4'b0001;
    evt = 8'h89;
    step();
    evt = 8'h08;
    step();
    evt = '0;
    run(200);
    ex(16 + 0, -1);
    ex(16 + 3, -1);
    ex(16 + 7, -1);
    ex(0, 0);
    compare("R9");

    // R4: every pointer value against every request mask
    for (int p = 0; p < NR; p++) begin
      for (int m = 1; m < (1 << NR); m++) begin
        len = '0;
        req = NR'(1 << ((p + NR - 1) % NR));
        run(100);
        ex((p + NR - 1) % NR, 0);
        compare("R4");
        req = NR'(m);
        run(100);
        for (int k = 0; k < NR; k++)
          if (m[(p + k) % NR]) ex((p + k) % NR, 0);
        chk(own_log[0] == exp_own[0], "R5", own_log[0], exp_own[0]);
        compare("R4");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule